// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block gathers 32-bit words written by a host into a 2048-byte transmit buffer and turns them into an outgoing byte stream. The first word written into an empty buffer is special: its low 16 bits give the payload length of the frame that follows. Every accepted word, the length word included, is appended to the buffer as four bytes with the least significant byte first. The emitted frame starts at buffer byte 2, just past the length field, and covers the header and payload.

Transmission starts in one of two ways. The first is automatic: after a write, the new fill level is compared with a programmable threshold and with the number of bytes a complete frame needs, and the frame is sent when both are met. The second is forced: a request strobe sends whatever is in the buffer. Short frames can be padded with zeros up to the minimum Ethernet size. While a frame streams out, the block reports busy and refuses further host words. Each frame end raises a one-cycle "transmit empty" pulse. An over-long length word raises a one-cycle "transmit error" pulse instead.

The host side keeps its control fields in its own register file and drives them onto the ports: pad enable, auto-CRC and the 6-bit threshold. The reset value of the threshold in that register file is expected to be 63, which leaves automatic sending off.

Top module: `etx_frame_builder`

## Requirements
- R1: When the buffer is empty and `wr_data[15:0]` of an accepted write exceeds 2032, the word is dropped. `tx_err` is high for exactly the one cycle after that write. The buffer stays empty, so the next word is taken as the length word.
- R2: An accepted word is stored as four bytes, bits [7:0] first and bits [31:24] last. Frame byte k on `out_data` is buffer byte k+2, counting the first byte of the length word as buffer byte 0.
- R3: After each accepted write, a send starts when three conditions all hold. First, `thresh` is not 63. Second, the fill level is at least 32*thresh+4 bytes. Third, the fill level is at least min(length+16, 2048) bytes with `crc_auto`=1, or min(length+20, 2048) bytes with `crc_auto`=0. `out_valid` rises on the cycle after that write.
- R4: A `send_req` pulse while idle starts a send of the buffered frame on the next cycle, whatever the threshold and the fill level.
- R5: The frame has length+14 bytes. With `pad_en`=1 and length+14 below 60, it has exactly 60 bytes, and bytes from index length+14 onward are zero. No frame exceeds 2046 bytes.
- R6: `out_last` marks the final byte. One cycle after that byte's handshake, `out_valid` is low and `tx_empty` is high for exactly one cycle. The buffer is then empty.
- R7: An `err_ack` pulse while idle empties the buffer. A write or a `send_req` in the same cycle is not taken.
- R8: Once 2048 bytes are held, further writes are dropped, and the buffered bytes keep their values.
- R9: While a frame streams out, `busy` is high and writes are not accepted. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: After reset, `out_valid`, `busy`, `tx_err` and `tx_empty` are low, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host word; the first word of a frame holds the payload length in [15:0] |
| busy | output | 1 | High while a frame streams out; writes are refused |
| pad_en | input | 1 | Pad short frames with zeros to 60 bytes |
| crc_auto | input | 1 | 1: the buffered frame carries no CRC bytes |
| thresh | input | 6 | Fill threshold for automatic send; 63 disables it |
| send_req | input | 1 | Force a send of the buffered frame |
| err_ack | input | 1 | Acknowledge a transmit error; empties the buffer |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_last | output | 1 | Final byte of the frame |
| tx_err | output | 1 | One-cycle pulse: over-long length word rejected |
| tx_empty | output | 1 | One-cycle pulse: frame fully sent, buffer empty |

## Verification
The corners that are hardest to reach from the ports are at the buffer's capacity. One is the 2032-byte payload, whose completeness need is clipped to the full 2048 bytes. The other is the over-full buffer that must drop words and still send correctly. Both are reached only after hundreds of consecutive writes. Directed sequences write all 512 words, and for the overflow case a few more, then compare every one of the 2046 streamed bytes. Seeded random frames vary the length, threshold, pad and auto-CRC settings and the sink's readiness. A bench model predicts the exact write after which each automatic send must begin.

// File: rtl/etx_pkg.sv
`timescale 1ns/1ps
// Shared sizing defaults for the transmit frame assembler.
// Assumes byte-addressed storage built from 32-bit host words.
package etx_pkg;
    localparam int unsigned ETX_BUF_BYTES  = 2048;
    localparam int unsigned ETX_WORD_BYTES = 4;
    localparam int unsigned ETX_LEN_MAX    = 2032;
    localparam int unsigned ETX_HDR_BYTES  = 14;
    localparam int unsigned ETX_LEAD_BYTES = 2;
    localparam int unsigned ETX_MIN_FRAME  = 60;
    localparam int unsigned ETX_CRC_BYTES  = 4;
endpackage

// File: rtl/etx_word_store.sv
`timescale 1ns/1ps
// Word-wide frame buffer with a byte-wide asynchronous read port.
// Assumes one write per cycle at word granularity. The read address is a
// byte address whose low bits pick a lane, least significant lane first.
module etx_word_store #(
    parameter int WORDS   = 512,
    parameter int WADDR_W = $clog2(WORDS),
    parameter int ADDR_W  = WADDR_W + 2
) (
    input  logic               clk,
    input  logic               we,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [31:0]        wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [7:0]         rbyte
);
    logic [31:0] mem [WORDS];
    logic [31:0] rword;

    // Store an accepted host word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Select the addressed byte lane of the addressed word.
    always_comb begin
        rword = mem[raddr[ADDR_W-1:2]];
        rbyte = rword[{raddr[1:0], 3'b000} +: 8];
    end
endmodule

// File: rtl/etx_launch_ctrl.sv
`timescale 1ns/1ps
// Fill tracking, length capture and the send decision.
// Assumes wr_take already excludes busy and error-acknowledge cycles.
// The decision uses the fill level as it stands after the current write.
module etx_launch_ctrl #(
    parameter int BUF_BYTES  = 2048,
    parameter int WORD_BYTES = 4,
    parameter int LEN_MAX    = 2032,
    parameter int OVERHEAD   = 16,
    parameter int CRC_BYTES  = 4,
    parameter int THR_W      = 6,
    parameter int FILL_W     = $clog2(BUF_BYTES + 1),
    parameter int ADDR_W     = $clog2(BUF_BYTES),
    parameter int LEN_W      = $clog2(LEN_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_take,
    input  logic [15:0]         len_word,
    input  logic                crc_auto,
    input  logic [THR_W-1:0]    thresh,
    input  logic                send_req,
    input  logic                err_ack,
    input  logic                busy,
    input  logic                done,
    output logic                store_en,
    output logic [ADDR_W-3:0]   store_addr,
    output logic [LEN_W-1:0]    len_next,
    output logic                start,
    output logic                tx_err
);
    localparam int CW = FILL_W + 1;
    localparam logic [THR_W-1:0] THR_OFF = '1;

    logic [FILL_W-1:0] fill_q;
    logic [LEN_W-1:0]  len_q;
    logic              err_q;
    logic              first_w, too_long, take, room, auto_go;
    logic [CW-1:0]     fill_ext, fill_after, need, thr_level;

    // Evaluate the write, the new fill level and the send decision.
    always_comb begin
        first_w    = (fill_q == '0);
        too_long   = first_w && (len_word > 16'(LEN_MAX));
        take       = wr_take && !too_long;
        fill_ext   = CW'(fill_q);
        room       = (fill_ext + CW'(WORD_BYTES)) <= CW'(BUF_BYTES);
        store_en   = take && room;
        store_addr = fill_q[ADDR_W-1:2];
        fill_after = store_en ? fill_ext + CW'(WORD_BYTES) : fill_ext;
        len_next   = (take && first_w) ? len_word[LEN_W-1:0] : len_q;
        need       = CW'(len_next) + CW'(OVERHEAD) + (crc_auto ? CW'(0) : CW'(CRC_BYTES));
        if (need > CW'(BUF_BYTES)) begin
            need = CW'(BUF_BYTES);
        end
        thr_level  = (CW'(thresh) * CW'(8) + CW'(1)) * CW'(WORD_BYTES);
        auto_go    = take && (thresh != THR_OFF) && (fill_after >= thr_level)
                     && (fill_after >= need);
        start      = !busy && !err_ack && (auto_go || send_req);
    end

    // Hold the fill level, the captured length and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            len_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= wr_take && too_long;
            len_q <= len_next;
            if ((err_ack && !busy) || done) begin
                fill_q <= '0;
            end else begin
                fill_q <= FILL_W'(fill_after);
            end
        end
    end

    assign tx_err = err_q;
endmodule

// File: rtl/etx_byte_streamer.sv
`timescale 1ns/1ps
// Streams one frame byte per handshake from the buffer.
// Assumes start is only raised while idle. The length and pad choice are
// captured at start; bytes past the unpadded length read as zero.
module etx_byte_streamer #(
    parameter int ADDR_W     = 11,
    parameter int LEN_W      = 11,
    parameter int HDR_BYTES  = 14,
    parameter int LEAD_BYTES = 2,
    parameter int MIN_FRAME  = 60,
    parameter int CAP_BYTES  = 2046
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              pad_en,
    input  logic              out_ready,
    output logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              in_pad,
    output logic              last,
    output logic              done,
    output logic              tx_empty
);
    localparam int LW = ADDR_W + 1;

    logic [LW-1:0] idx_q, flen_q, raw_q;
    logic [LW-1:0] raw_c, flen_c;
    logic          busy_q, empty_q;

    // Frame length at start, then the position flags of the current byte.
    always_comb begin
        raw_c  = LW'(len) + LW'(HDR_BYTES);
        flen_c = (pad_en && (raw_c < LW'(MIN_FRAME))) ? LW'(MIN_FRAME) : raw_c;
        if (flen_c > LW'(CAP_BYTES)) begin
            flen_c = LW'(CAP_BYTES);
        end
        last    = busy_q && (idx_q == flen_q - LW'(1));
        done    = last && out_ready;
        in_pad  = idx_q >= raw_q;
        rd_addr = ADDR_W'(idx_q + LW'(LEAD_BYTES));
    end

    // Advance through the frame and signal its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            flen_q  <= '0;
            raw_q   <= '0;
            empty_q <= 1'b0;
        end else begin
            empty_q <= done;
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                flen_q <= flen_c;
                raw_q  <= raw_c;
            end else if (busy_q && out_ready) begin
                if (last) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + LW'(1);
                end
            end
        end
    end

    assign busy     = busy_q;
    assign tx_empty = empty_q;
endmodule

// File: rtl/etx_frame_builder.sv
`timescale 1ns/1ps
// Ethernet transmit frame assembler: host words in, frame bytes out.
// Assumes the host holds its control fields steady while a frame streams.
// Refuses writes while busy; an error acknowledge takes precedence over a
// write or a send request in the same cycle.
module etx_frame_builder
    import etx_pkg::*;
#(
    parameter int BUF_BYTES  = ETX_BUF_BYTES,
    parameter int WORD_BYTES = ETX_WORD_BYTES,
    parameter int LEN_MAX    = ETX_LEN_MAX,
    parameter int HDR_BYTES  = ETX_HDR_BYTES,
    parameter int LEAD_BYTES = ETX_LEAD_BYTES,
    parameter int MIN_FRAME  = ETX_MIN_FRAME,
    parameter int CRC_BYTES  = ETX_CRC_BYTES,
    parameter int THR_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic             busy,
    input  logic             pad_en,
    input  logic             crc_auto,
    input  logic [THR_W-1:0] thresh,
    input  logic             send_req,
    input  logic             err_ack,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last,
    output logic             tx_err,
    output logic             tx_empty
);
    localparam int WORDS     = BUF_BYTES / WORD_BYTES;
    localparam int ADDR_W    = $clog2(BUF_BYTES);
    localparam int WADDR_W   = ADDR_W - 2;
    localparam int FILL_W    = $clog2(BUF_BYTES + 1);
    localparam int LEN_W     = $clog2(LEN_MAX + 1);
    localparam int CAP_BYTES = BUF_BYTES - LEAD_BYTES;
    localparam int OVERHEAD  = HDR_BYTES + LEAD_BYTES;

    logic               wr_take, store_en, start, done, in_pad, busy_i;
    logic [WADDR_W-1:0] store_addr;
    logic [LEN_W-1:0]   len_next;
    logic [ADDR_W-1:0]  rd_addr;
    logic [7:0]         rbyte;

    // Accept a host word only while idle and not acknowledging an error.
    assign wr_take = wr_en && !busy_i && !err_ack;

    etx_launch_ctrl #(
        .BUF_BYTES (BUF_BYTES),
        .WORD_BYTES(WORD_BYTES),
        .LEN_MAX   (LEN_MAX),
        .OVERHEAD  (OVERHEAD),
        .CRC_BYTES (CRC_BYTES),
        .THR_W     (THR_W),
        .FILL_W    (FILL_W),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_take   (wr_take),
        .len_word  (wr_data[15:0]),
        .crc_auto  (crc_auto),
        .thresh    (thresh),
        .send_req  (send_req),
        .err_ack   (err_ack),
        .busy      (busy_i),
        .done      (done),
        .store_en  (store_en),
        .store_addr(store_addr),
        .len_next  (len_next),
        .start     (start),
        .tx_err    (tx_err)
    );

    etx_word_store #(
        .WORDS  (WORDS),
        .WADDR_W(WADDR_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk  (clk),
        .we   (store_en),
        .waddr(store_addr),
        .wdata(wr_data),
        .raddr(rd_addr),
        .rbyte(rbyte)
    );

    etx_byte_streamer #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .HDR_BYTES (HDR_BYTES),
        .LEAD_BYTES(LEAD_BYTES),
        .MIN_FRAME (MIN_FRAME),
        .CAP_BYTES (CAP_BYTES)
    ) u_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len      (len_next),
        .pad_en   (pad_en),
        .out_ready(out_ready),
        .busy     (busy_i),
        .rd_addr  (rd_addr),
        .in_pad   (in_pad),
        .last     (out_last),
        .done     (done),
        .tx_empty (tx_empty)
    );

    // Pad region reads as zero; otherwise the buffered byte.
    assign out_data  = in_pad ? 8'h00 : rbyte;
    assign out_valid = busy_i;
    assign busy      = busy_i;
endmodule

// File: rtl/etx_frame_builder_chk.sv
`timescale 1ns/1ps
// Protocol checker for the transmit frame assembler, attached by bind.
// Assumes only the ports of the top module.
module etx_frame_builder_chk #(
    parameter int CAP_BYTES = 2046,
    parameter int HDR_BYTES = 14,
    parameter int CNT_W     = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       busy,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_last,
    input logic       tx_err,
    input logic       tx_empty
);
    logic [CNT_W-1:0] beats;

    // Count bytes handed over in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats <= '0;
        end else if (out_valid && out_ready) begin
            beats <= out_last ? '0 : beats + CNT_W'(1);
        end
    end

    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> $past(wr_en && !busy)); // R1
    AST_EMPTY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> $past(out_valid && out_ready && out_last)); // R6
    AST_VALID_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready && out_last)); // R6
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
    AST_FRAME_SIZE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |->
            (beats >= CNT_W'(HDR_BYTES - 1) && beats <= CNT_W'(CAP_BYTES - 1))); // R5
endmodule

bind etx_frame_builder etx_frame_builder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .busy     (busy),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_last (out_last),
    .tx_err   (tx_err),
    .tx_empty (tx_empty)
);

// File: tb/etx_frame_builder_bench.sv
`timescale 1ns/1ps
module etx_frame_builder_bench;
    localparam int BUF  = 2048;
    localparam int LMAX = 2032;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        busy;
    logic        pad_en = 1'b0;
    logic        crc_auto = 1'b1;
    logic [5:0]  thresh = 6'd63;
    logic        send_req = 1'b0;
    logic        err_ack = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_last;
    logic        tx_err;
    logic        tx_empty;

    always #2.5 clk = ~clk;

    etx_frame_builder u_etx_frame_builder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
        .pad_en(pad_en), .crc_auto(crc_auto), .thresh(thresh), .send_req(send_req),
        .err_ack(err_ack), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_last(out_last), .tx_err(tx_err), .tx_empty(tx_empty)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_buf [BUF];
    int  m_fill = 0;
    int  m_len  = 0;
    bit  last_auto = 0;
    logic [7:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Model of one accepted write; returns whether a send must start.
    function automatic bit model_write(input logic [31:0] w, output bit err);
        int need;
        err = 0;
        if (m_fill == 0 && int'(w[15:0]) > LMAX) begin
            err = 1;
            return 0;
        end
        if (m_fill == 0) m_len = int'(w[15:0]);
        if (m_fill + 4 <= BUF) begin
            for (int k = 0; k < 4; k++) m_buf[m_fill + k] = w[8*k +: 8];
            m_fill += 4;
        end
        need = m_len + 16 + (crc_auto ? 0 : 4);
        if (need > BUF) need = BUF;
        return (thresh != 6'd63) && (m_fill >= 32 * int'(thresh) + 4) && (m_fill >= need);
    endfunction

    function automatic void build_expected();
        int raw, fl;
        exp_q.delete();
        raw = m_len + 14;
        fl  = (pad_en && raw < 60) ? 60 : raw;
        if (fl > BUF - 2) fl = BUF - 2;
        for (int k = 0; k < fl; k++) exp_q.push_back(k < raw ? m_buf[k + 2] : 8'h00);
    endfunction

    task automatic do_write(input logic [31:0] w, input string req);
        bit err, au;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        au = model_write(w, err);
        @(negedge clk);
        wr_en = 1'b0;
        chk(tx_err == err, req, "tx_err after write", int'(tx_err), int'(err));
        chk(out_valid == au, req, "send start after write", int'(out_valid), int'(au));
        last_auto = au;
    endtask

    task automatic recv_frame(input string req);
        int n = 0, bad = 0, stall_bad = 0, lim = 0, first_bad = -1, ga = 0, ea = 0;
        bit fin = 0, prev_stall = 0;
        logic [7:0] prev_d = '0;
        build_expected();
        while (!fin && lim < 20000) begin
            out_ready = ($urandom % 4) != 0;
            if (prev_stall && (!out_valid || out_data !== prev_d)) stall_bad++;
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            if (out_valid && out_ready) begin
                if (n >= exp_q.size() || out_data !== exp_q[n]) begin
                    if (first_bad < 0) begin
                        first_bad = n;
                        ga = int'(out_data);
                        ea = (n < exp_q.size()) ? int'(exp_q[n]) : -1;
                    end
                    bad++;
                end
                n++;
                if (out_last) fin = 1;
            end
            @(negedge clk);
            lim++;
        end
        out_ready = 1'b0;
        m_fill = 0;
        chk(bad == 0, "R2", $sformatf("%s frame byte %0d", req, first_bad), ga, ea);
        chk(n == exp_q.size(), "R5", {req, " frame length"}, n, exp_q.size());
        chk(stall_bad == 0, "R9", {req, " hold under stall"}, stall_bad, 0);
        chk(tx_empty == 1'b1 && out_valid == 1'b0, "R6", {req, " tx_empty after last"}, int'(tx_empty), 1);
        @(negedge clk);
        chk(tx_empty == 1'b0, "R6", {req, " tx_empty lasts one cycle"}, int'(tx_empty), 0);
    endtask

    task automatic force_send(input string req);
        @(negedge clk);
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
        chk(out_valid == 1'b1, "R4", {req, " forced send starts"}, int'(out_valid), 1);
        recv_frame(req);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(out_valid == 0 && busy == 0, "R10", "idle after reset", int'(out_valid | busy), 0);
        chk(tx_err == 0 && tx_empty == 0, "R10", "no pulses after reset", int'(tx_err | tx_empty), 0);

        // R3 and R5: automatic send with padding, auto-CRC on
        thresh = 6'd0; crc_auto = 1'b1; pad_en = 1'b1;
        do_write(32'hA1B2_000A, "R3 pad");
        for (int i = 0; i < 6; i++) do_write(32'h0403_0201 + 32'h0404_0404 * i, "R3 pad");
        chk(last_auto == 1, "R3", "send after seventh word", int'(last_auto), 1);
        recv_frame("R5 padded");

        // R3: auto-CRC off needs four more bytes
        crc_auto = 1'b0; pad_en = 1'b0;
        do_write(32'h0000_000A, "R3 nocrc");
        for (int i = 0; i < 7; i++) do_write($urandom, "R3 nocrc");
        recv_frame("R3 nocrc");

        // R3: threshold above completeness delays the send
        thresh = 6'd2; crc_auto = 1'b1;
        do_write(32'h0000_000A, "R3 thresh");
        for (int i = 0; i < 16; i++) do_write($urandom, "R3 thresh");
        recv_frame("R3 thresh");

        // R4: threshold 63 never sends by itself
        thresh = 6'd63;
        do_write(32'h0000_000A, "R4 off");
        for (int i = 0; i < 9; i++) do_write($urandom, "R4 off");
        force_send("R4 forced");

        // R1: over-long length rejected, next word is the length word
        thresh = 6'd0;
        do_write(32'h0000_07F1, "R1 too long");
        do_write(32'hCAFE_0004, "R1 after reject");
        for (int i = 0; i < 4; i++) do_write($urandom, "R1 after reject");
        recv_frame("R1 frame");

        // R7: error acknowledge empties the buffer
        thresh = 6'd63;
        do_write(32'h0000_000A, "R7 pre");
        do_write($urandom, "R7 pre");
        do_write($urandom, "R7 pre");
        @(negedge clk); err_ack = 1'b1; wr_en = 1'b1; wr_data = 32'h1111_1111;
        @(negedge clk); err_ack = 1'b0; wr_en = 1'b0;
        m_fill = 0;
        do_write(32'h0000_0006, "R7 post");
        for (int i = 0; i < 5; i++) do_write($urandom, "R7 post");
        force_send("R7 refill");

        // R9: busy refuses writes and stalls hold the output
        thresh = 6'd0; pad_en = 1'b1; crc_auto = 1'b1;
        do_write(32'h0000_0000, "R9 setup");
        for (int i = 0; i < 3; i++) do_write($urandom, "R9 setup");
        held = out_data;
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h0000_0005;
        chk(busy == 1'b1, "R9", "busy while streaming", int'(busy), 1);
        @(negedge clk); wr_en = 1'b0;
        chk(out_valid == 1'b1 && out_data == held, "R9", "held byte under stall", int'(out_data), int'(held));
        recv_frame("R9 frame");

        // R5 and R3: largest payload, completeness clipped to full buffer
        pad_en = 1'b0;
        do_write(32'h0000_07F0, "R5 max");
        for (int i = 0; i < 511; i++) do_write($urandom, "R5 max");
        recv_frame("R5 max");

        // R8: words beyond capacity are dropped
        thresh = 6'd63;
        do_write(32'h0000_07F0, "R8 fill");
        for (int i = 0; i < 514; i++) do_write($urandom, "R8 fill");
        chk(m_fill == BUF, "R8", "model full", m_fill, BUF);
        force_send("R8 overflow");

        // Random frames across thresholds, pad and auto-CRC settings
        for (int f = 0; f < 40; f++) begin
            int r, len, lim, cnt;
            r = $urandom % 6;
            thresh = (r == 5) ? 6'd63 : 6'(r);
            crc_auto = 1'($urandom % 2);
            pad_en = 1'($urandom % 2);
            len = $urandom % 120;
            do_write({16'($urandom), 16'(len)}, "R3 random");
            lim = (len + 24) / 4 + 8 * r + 3;
            cnt = 1;
            while (!last_auto && cnt < lim) begin
                do_write($urandom, "R3 random");
                cnt++;
            end
            if (last_auto) recv_frame("R3 random");
            else force_send("R4 random");
        end

        summary();
        $finish;
    end
endmodule